// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by reading page table entries from memory. A request carries the virtual address, the kind of access (load, store or instruction fetch), whether the requester runs in user or supervisor mode, and two permission-relaxing flags. The first table sits at the root page number supplied by the address-translation register. Each step reads one 4-byte entry. A step either descends to the next table, finds a leaf, or stops with a fault.

When a leaf is found, the walker checks it in a fixed order: superpage alignment first, then the user-page rule, then the read/write/execute rule. If the accessed or dirty flag still has to be set, the configuration input chooses between two actions. The walker either reports a page fault, or it issues one atomic compare-and-update to memory. If that compare fails because another agent changed the entry, the walker reads the same entry again. Only one request is in flight at a time. The result comes back as a single-cycle pulse carrying either the physical address or a fault code.

Top module: `page_walk_unit`

## Requirements
- R1: The first entry read is at root_ppn*4096 + va[31:22]*4. A pointer entry (V=1, R=0, W=0, X=0) at the top level leads to a second read at entry.ppn*4096 + va[21:12]*4. The entry flag bits are V=bit0, R=bit1, W=bit2, X=bit3, U=bit4, A=bit6, D=bit7, ppn low part = bits 19:10, ppn high part = bits 31:20.
- R2: A read response flagged with an error ends the walk with done_fault=2 (access fault).
- R3: Each of these ends the walk with done_fault=1 (page fault): an entry with V=0; an entry with R=0 and W=1; a pointer entry found at the second level.
- R4: A leaf found at the top level whose ppn low part (bits 19:10) is nonzero is a page fault.
- R5: In user mode (req_user=1) a leaf needs U=1. In supervisor mode, a U=1 leaf is allowed only for loads and stores with req_sum=1, and never for fetches. Any violation is a page fault.
- R6: req_kind 0 (load) needs R=1, or X=1 when req_mxr=1. Kind 1 (store) needs W=1. Kind 2 (fetch) needs X=1. Any violation is a page fault.
- R7: When A=0, or when a store finds D=0, and ad_fault_en=1, the walk ends with a page fault and no memory write is issued.
- R8: With ad_fault_en=0, that case issues one write request. Its compare value (mem_cmp) is the entry as read. Its new value (mem_wdata) is the entry with A set, and with D also set for stores. A response with mem_rsp_cmp_fail=1 makes the walker read the same entry again and redo the checks.
- R9: On success, done_paddr = {ppn high, ppn low, va[11:0]}. For a top-level leaf, va[21:12] replaces the ppn low part.
- R10: req_ready is high only when idle. It drops in the cycle after a request is accepted. done_valid is a one-cycle pulse, and done_fault is 0 on success.
- R11: After reset, req_ready=1, done_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 user mode, 0 supervisor |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_mxr | input | 1 | Executable pages readable |
| root_ppn | input | 22 | Root table page number |
| ad_fault_en | input | 1 | Fault instead of updating A/D |
| mem_req_valid | output | 1 | Memory request, one cycle |
| mem_write | output | 1 | Request is compare-and-update |
| mem_addr | output | 34 | Entry byte address |
| mem_wdata | output | 32 | New entry value |
| mem_cmp | output | 32 | Expected entry value |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Access error |
| mem_rsp_cmp_fail | input | 1 | Compare mismatch, no write done |
| done_valid | output | 1 | Result pulse |
| done_paddr | output | 34 | Physical address |
| done_fault | output | 2 | 0 none, 1 page fault, 2 access fault |

## Verification
The embedded properties check, on every cycle, the handshake rules: ready falls after acceptance, the result is a single pulse, memory requests are single-cycle, and no request is issued while idle. They also check that every compare-and-update differs from its compare value only in the A/D bits and sets A. The fault decisions, the address arithmetic for pointers and superpages, the ordering of the leaf checks, and the restart after a failed compare depend on table contents in memory. Only the bench scenarios show these, using a fixed page table and a memory model that can inject errors and concurrent modifications.

// File: rtl/page_walk_unit.sv
module page_walk_unit #(
  parameter int VA_W  = 32,
  parameter int PPN_W = 22,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [1:0]             req_kind,
  input  logic                   req_user,
  input  logic                   req_sum,
  input  logic                   req_mxr,
  input  logic [PPN_W-1:0]       root_ppn,
  input  logic                   ad_fault_en,
  output logic                   mem_req_valid,
  output logic                   mem_write,
  output logic [PPN_W+OFF_W-1:0] mem_addr,
  output logic [31:0]            mem_wdata,
  output logic [31:0]            mem_cmp,
  input  logic                   mem_rsp_valid,
  input  logic [31:0]            mem_rsp_data,
  input  logic                   mem_rsp_err,
  input  logic                   mem_rsp_cmp_fail,
  output logic                   done_valid,
  output logic [PPN_W+OFF_W-1:0] done_paddr,
  output logic [1:0]             done_fault
);
  localparam int VPN_W = (VA_W - OFF_W) / 2;
  localparam int PA_W  = PPN_W + OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RD_WAIT, S_CHK, S_UPD, S_UPD_WAIT, S_FIN} state_t;

  state_t            state;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        kind_q;
  logic              user_q, sum_q, mxr_q, adfe_q, lvl_q;
  logic [PPN_W-1:0]  base_q;
  logic [31:0]       pte_q;
  logic [1:0]        fault_q;

  logic pv, pr, pw, px, pu, pa, pd;
  assign {pd, pa, pu, px, pw, pr, pv} = {pte_q[7:6], pte_q[4:0]};

  logic is_store, is_fetch;
  assign is_store = (kind_q == 2'd1);
  assign is_fetch = (kind_q == 2'd2);

  logic [VPN_W-1:0] vpn_sel;
  assign vpn_sel = lvl_q ? va_q[VA_W-1 -: VPN_W] : va_q[OFF_W +: VPN_W];

  logic bad_pte, leaf, misal, u_bad, perm_ok, need_ad;
  assign bad_pte = !pv || (!pr && pw);
  assign leaf    = pr || px;
  assign misal   = lvl_q && (pte_q[10 +: VPN_W] != '0);
  assign u_bad   = user_q ? !pu : (pu && (is_fetch || !sum_q));
  assign perm_ok = is_fetch ? px : (is_store ? pw : (pr || (mxr_q && px)));
  assign need_ad = !pa || (is_store && !pd);

  logic [31:0] upd_pte;
  assign upd_pte = pte_q | 32'h40 | (is_store ? 32'h80 : 32'h0);

  logic [PA_W-1:0] leaf_paddr;
  assign leaf_paddr = {pte_q[31:10+VPN_W],
                       (lvl_q ? va_q[OFF_W +: VPN_W] : pte_q[10 +: VPN_W]),
                       va_q[OFF_W-1:0]};

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_RD) || (state == S_UPD);
  assign mem_write     = (state == S_UPD);
  assign mem_addr      = {base_q, vpn_sel, 2'b00};
  assign mem_wdata     = upd_pte;
  assign mem_cmp       = pte_q;
  assign done_valid    = (state == S_FIN);
  assign done_fault    = fault_q;
  assign done_paddr    = (done_valid && fault_q == 2'd0) ? leaf_paddr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      kind_q  <= '0;
      user_q  <= 1'b0;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      adfe_q  <= 1'b0;
      lvl_q   <= 1'b0;
      base_q  <= '0;
      pte_q   <= '0;
      fault_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          kind_q  <= req_kind;
          user_q  <= req_user;
          sum_q   <= req_sum;
          mxr_q   <= req_mxr;
          adfe_q  <= ad_fault_en;
          lvl_q   <= 1'b1;
          base_q  <= root_ppn;
          fault_q <= 2'd0;
          state   <= S_RD;
        end
        S_RD: state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_data;
          if (mem_rsp_err) begin
            fault_q <= 2'd2;
            state   <= S_FIN;
          end else begin
            state <= S_CHK;
          end
        end
        S_CHK: begin
          if (bad_pte) begin
            fault_q <= 2'd1;
            state   <= S_FIN;
          end else if (!leaf) begin
            if (!lvl_q) begin
              fault_q <= 2'd1;
              state   <= S_FIN;
            end else begin
              lvl_q  <= 1'b0;
              base_q <= pte_q[31:10];
              state  <= S_RD;
            end
          end else if (misal || u_bad || !perm_ok) begin
            fault_q <= 2'd1;
            state   <= S_FIN;
          end else if (need_ad) begin
            if (adfe_q) begin
              fault_q <= 2'd1;
              state   <= S_FIN;
            end else begin
              state <= S_UPD;
            end
          end else begin
            state <= S_FIN;
          end
        end
        S_UPD: state <= S_UPD_WAIT;
        S_UPD_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fault_q <= 2'd2;
            state   <= S_FIN;
          end else if (mem_rsp_cmp_fail) begin
            state <= S_RD;
          end else begin
            pte_q <= upd_pte;
            state <= S_FIN;
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R10
  AST_MEM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R1
  AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R1
  AST_UPD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_write) |-> (mem_wdata[6] && (((mem_wdata ^ mem_cmp) & ~32'hC0) == 32'h0))); // R8
endmodule

// File: tb/test_page_walk_unit.sv
module test_page_walk_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
  logic [21:0] root_ppn = 22'h100;
  logic        ad_fault_en = 1'b0;
  logic        mem_req_valid, mem_write;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_cmp;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0, mem_rsp_cmp_fail = 1'b0;
  logic        done_valid;
  logic [33:0] done_paddr;
  logic [1:0]  done_fault;

  page_walk_unit i_page_walk_unit (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_kind, .req_user,
    .req_sum, .req_mxr, .root_ppn, .ad_fault_en, .mem_req_valid, .mem_write,
    .mem_addr, .mem_wdata, .mem_cmp, .mem_rsp_valid, .mem_rsp_data,
    .mem_rsp_err, .mem_rsp_cmp_fail, .done_valid, .done_paddr, .done_fault);

  int checks = 0;
  int errors = 0;

  // memory model: one-cycle latency, compare-and-update is atomic here
  logic [31:0] mem [int unsigned];
  int unsigned rd_log [int];
  int          reads = 0;
  int          writes = 0;
  int unsigned err_key = 32'h80005;
  logic        interfere = 1'b0;
  logic [31:0] interfere_val = '0;
  logic        pend = 1'b0, pend_err = 1'b0, pend_fail = 1'b0;
  logic [31:0] pend_data = '0;

  always @(negedge clk) begin
    mem_rsp_valid    <= pend;
    mem_rsp_data     <= pend_data;
    mem_rsp_err      <= pend_err;
    mem_rsp_cmp_fail <= pend_fail;
    pend = mem_req_valid;
    if (mem_req_valid) begin
      int unsigned k;
      logic [31:0] cur;
      k = int'(mem_addr[33:2]);
      pend_err  = (k == err_key);
      pend_fail = 1'b0;
      if (!mem_write) begin
        rd_log[reads] = {mem_addr[31:0]};
        reads = reads + 1;
        pend_data = mem.exists(k) ? mem[k] : 32'h0;
      end else begin
        if (interfere) begin
          mem[k] = interfere_val;
          interfere = 1'b0;
        end
        cur = mem.exists(k) ? mem[k] : 32'h0;
        pend_data = cur;
        if (cur == mem_cmp) begin
          mem[k] = mem_wdata;
          writes = writes + 1;
        end else begin
          pend_fail = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic busy_ok, pulse_ok;

  task automatic run(input logic [31:0] va, input logic [1:0] kind, input logic u,
                     input logic s, input logic m, input logic adfe,
                     output logic [1:0] f, output logic [33:0] pa);
    int n;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_user = u; req_sum = s; req_mxr = m;
    ad_fault_en = adfe; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready;
    n = 0;
    while (!done_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    f = done_fault;
    pa = done_paddr;
    @(negedge clk);
    pulse_ok = !done_valid;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        user;
    logic        sum;
    logic        mxr;
    logic [1:0]  fault;
    logic [33:0] pa;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h00001ABC, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 34'h012345ABC, 4'd9},  // R9 user load
    '{32'h00001ABC, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 34'h0,         4'd6},  // R6 no W
    '{32'h00001ABC, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 34'h0,         4'd5},  // R5 sup, SUM=0
    '{32'h00001ABC, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 34'h012345ABC, 4'd5},  // R5 sup, SUM=1
    '{32'h00001ABC, 2'd2, 1'b0, 1'b1, 1'b0, 2'd1, 34'h0,         4'd5},  // R5 sup fetch
    '{32'h00001ABC, 2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 34'h012345ABC, 4'd6},  // R6 user fetch
    '{32'h00002010, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 34'h000777010, 4'd6},  // R6 exec only
    '{32'h00002010, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 34'h0,         4'd6},  // R6 MXR=0
    '{32'h00002010, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 34'h000777010, 4'd6},  // R6 MXR=1
    '{32'h00002010, 2'd2, 1'b1, 1'b0, 1'b0, 2'd1, 34'h0,         4'd5},  // R5 user on U=0
    '{32'h00456789, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 34'h001456789, 4'd9},  // R9 superpage
    '{32'h00456789, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 34'h001456789, 4'd9},  // R9 superpage store
    '{32'h00800000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 34'h0,         4'd4},  // R4 misaligned
    '{32'h00C00000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 34'h0,         4'd3},  // R3 V=0
    '{32'h01000000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 34'h0,         4'd3},  // R3 R=0 W=1
    '{32'h00004000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 34'h0,         4'd3},  // R3 pointer at level 0
    '{32'h00005000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 34'h0,         4'd2},  // R2 read error
    '{32'h00007FFF, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 34'h3FFFFFFFF, 4'd9}   // R9 full width
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  f;
    logic [33:0] pa;
    int          n0, w0;
    // top level, key base 0x40000
    mem[32'h40000] = 32'h00080001;
    mem[32'h40001] = 32'h005000C7;
    mem[32'h40002] = 32'h005004C7;
    mem[32'h40003] = 32'h00000000;
    mem[32'h40004] = 32'h00000005;
    // second level, key base 0x80000
    mem[32'h80001] = 32'h048D14DB;
    mem[32'h80002] = 32'h001DDC49;
    mem[32'h80003] = 32'h00222007;
    mem[32'h80004] = 32'h00000001;
    mem[32'h80006] = 32'h00266447;
    mem[32'h80007] = 32'hFFFFFC43;

    repeat (3) @(negedge clk);
    chk("R11 ready", {63'd0, req_ready}, 64'd1);
    chk("R11 done", {63'd0, done_valid}, 64'd0);
    chk("R11 mem", {63'd0, mem_req_valid}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].va, VECS[i].kind, VECS[i].user, VECS[i].sum, VECS[i].mxr, 1'b0, f, pa);
      chk($sformatf("R%0d vec%0d fault", VECS[i].req, i), {62'd0, f}, {62'd0, VECS[i].fault});
      chk($sformatf("R%0d vec%0d paddr", VECS[i].req, i), {30'd0, pa}, {30'd0, VECS[i].pa});
    end

    // R1 walk addresses and R10 handshake
    n0 = reads;
    run(32'h00001ABC, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, f, pa);
    chk("R1 read count", 64'(reads - n0), 64'd2);
    chk("R1 first addr", 64'(rd_log[n0]), 64'h100000);
    chk("R1 second addr", 64'(rd_log[n0 + 1]), 64'h200004);
    chk("R10 ready low while busy", {63'd0, busy_ok}, 64'd1);
    chk("R10 done single pulse", {63'd0, pulse_ok}, 64'd1);

    // R7 fault instead of update, no write
    w0 = writes;
    run(32'h00003004, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, f, pa);
    chk("R7 A=0 fault", {62'd0, f}, 64'd1);
    chk("R7 no write", 64'(writes - w0), 64'd0);
    chk("R7 entry kept", {32'd0, mem[32'h80003]}, 64'h00222007);

    // R8 store sets A and D
    run(32'h00003004, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, f, pa);
    chk("R8 store ok", {30'd0, pa}, 64'h000888004);
    chk("R8 entry A D", {32'd0, mem[32'h80003]}, 64'h002220C7);

    // R8 load sets only A
    mem[32'h80003] = 32'h00222007;
    run(32'h00003004, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, f, pa);
    chk("R8 load fault", {62'd0, f}, 64'd0);
    chk("R8 entry A only", {32'd0, mem[32'h80003]}, 64'h00222047);

    // R7 store with A=1 D=0
    run(32'h00006008, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, f, pa);
    chk("R7 D=0 store fault", {62'd0, f}, 64'd1);
    run(32'h00006008, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, f, pa);
    chk("R7 load no update needed", {30'd0, pa}, 64'h000999008);

    // R8 compare failure restarts the read of the same entry
    mem[32'h80003] = 32'h00222007;
    interfere_val = 32'h00222047;
    interfere = 1'b1;
    n0 = reads;
    w0 = writes;
    run(32'h00003004, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, f, pa);
    chk("R8 restart result", {30'd0, pa}, 64'h000888004);
    chk("R8 restart reads", 64'(reads - n0), 64'd3);
    chk("R8 restart reread addr", 64'(rd_log[n0 + 2]), 64'h20000C);
    chk("R8 restart no write", 64'(writes - w0), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule